// File: doc/BRIEF.md
# Packet Timestamp Capture with Deferred Validation

This block samples a free-running time-stamp counter at the moment a start-of-frame delimiter passes the MAC boundary. Sampling is done separately for the receive and the transmit direction of each of four Ethernet ports. A header decoder outside the block later decides whether the frame is a precision time protocol packet. The sampled value is held until that decision arrives. A positive verdict turns the held value into a packet event, which is offered on a valid/ready stream to the event FIFO. A negative verdict drops the held value and produces nothing.

The verdict arrives some cycles after the delimiter. A packet stamped just before the counter wraps can therefore reach the FIFO after the wrap notification, while still carrying its pre-wrap value. Software resolves this by looking at the timestamp's top bit. The block carries the captured value through unchanged.

Each of the eight sources (direction × port) is numbered `dir*4 + port`, with receive as direction 0 and transmit as direction 1. A round-robin arbiter merges committed events into a single output register. Back-pressure: while `evt_valid` is high and `evt_ready` is low, the event fields are held stable. An event transfers on every edge where both signals are high. The decoder side has no back-pressure. Instead, a per-source event that is still waiting is replaced by a newer one, and the replacement is flagged as lossy.

Top module: `ptp_stamp_capture`

## Requirements
- R1: A delimiter strobe on any source samples `ts_count` on that clock edge. The event for that capture reports exactly that value in `evt_ts`, in both directions and on all four ports.
- R2: A verdict with `*_vd_keep`=1 on a source holding a capture yields exactly one event. `evt_dir` is 0 for receive and 1 for transmit, `evt_port` is the port, and `evt_msgid` is the identifier presented with the verdict. With the output free, `evt_valid` rises after the second clock edge counted from the verdict edge.
- R3: A verdict with `*_vd_keep`=0 clears the held capture and produces no event.
- R4: A verdict on a source that holds no capture has no effect and produces no event.
- R5: A second delimiter before the verdict overwrites the held timestamp and sets bit `dir*4+port` of `ovr_flag`. That bit clears when the verdict is taken, and the resulting event carries `evt_lost`=1 and the newer timestamp.
- R6: When a delimiter and a verdict arrive on the same source in the same cycle, the verdict applies to the older capture. The new capture starts with its overrun bit clear.
- R7: A kept verdict on a source whose previous event has not yet been granted replaces that waiting event. The replacement carries `evt_lost`=1.
- R8: Events committed together leave in round-robin order of source number. After reset the search starts at source 0, and afterwards it starts just past the last granted source.
- R9: While `evt_valid` is high and `evt_ready` is low, `evt_valid` and all event fields stay unchanged.
- R10: An event whose verdict arrives after the counter has wrapped still reports the value sampled before the wrap.
- R11: During reset `evt_valid` and every `ovr_flag` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_count | input | 32 | Current time-stamp counter value |
| rx_sfd | input | 4 | Receive delimiter strobe, one bit per port |
| tx_sfd | input | 4 | Transmit delimiter strobe, one bit per port |
| rx_vd_valid | input | 4 | Receive verdict strobe per port |
| rx_vd_keep | input | 4 | Receive verdict: 1 keep, 0 discard |
| rx_vd_msgid | input | 64 | Receive message identifier, 16 bits per port, port p at [16p+15:16p] |
| tx_vd_valid | input | 4 | Transmit verdict strobe per port |
| tx_vd_keep | input | 4 | Transmit verdict: 1 keep, 0 discard |
| tx_vd_msgid | input | 64 | Transmit message identifier, 16 bits per port |
| evt_valid | output | 1 | Packet event offered to the FIFO |
| evt_ready | input | 1 | FIFO accepts the event |
| evt_dir | output | 1 | 0 receive, 1 transmit |
| evt_port | output | 2 | Port number |
| evt_msgid | output | 16 | Message identifier from the verdict |
| evt_ts | output | 32 | Captured timestamp |
| evt_lost | output | 1 | An earlier capture or event of this source was overwritten |
| ovr_flag | output | 8 | Per-source overrun of the held capture, bit dir*4+port |

## Verification
The bench targets four corner cases: two delimiters before one verdict, a delimiter and a verdict landing in the same cycle, a verdict with nothing held, and a second kept verdict while the output is stalled. A design that mishandled these would report the stale timestamp, flag the wrong capture as lossy, invent an event, or silently drop the newer event. It commits all eight sources at once after reset and checks the drain order. A wrong rotation pointer would emit them out of order or starve one source. A capture is placed two cycles before a counter wrap with the verdict after it, to catch any design that re-samples the counter at commit time. Random traffic with stalls is scored per source against a model built from the requirements.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TS_W = 32;
  localparam int ID_W = 16;

  typedef struct packed {
    logic            lost;
    logic [ID_W-1:0] msgid;
    logic [TS_W-1:0] ts;
  } stamp_evt_t;
endpackage

// File: rtl/tsc_slot.sv
// One source (direction x port): a held capture plus one committed event.
module tsc_slot
  import tsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sfd,
  input  logic [TS_W-1:0] ts_now,
  input  logic            vd_valid,
  input  logic            vd_keep,
  input  logic [ID_W-1:0] vd_msgid,
  input  logic            grant,
  output logic            req,
  output stamp_evt_t      evt,
  output logic            cap_ovr
);
  logic            cap_vld;
  logic [TS_W-1:0] cap_ts;
  logic            cap_lost;
  logic            com_vld;
  stamp_evt_t      com_q;
  logic            hit;
  logic            promote;

  // A verdict only counts against a capture that is already held.
  assign hit     = vd_valid & cap_vld;
  assign promote = hit & vd_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_ts   <= '0;
      cap_lost <= 1'b0;
    end else if (sfd) begin
      cap_vld  <= 1'b1;
      cap_ts   <= ts_now;
      cap_lost <= cap_vld & ~hit;
    end else if (hit) begin
      cap_vld  <= 1'b0;
      cap_lost <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_vld <= 1'b0;
      com_q   <= '0;
    end else if (promote) begin
      com_vld     <= 1'b1;
      com_q.ts    <= cap_ts;
      com_q.msgid <= vd_msgid;
      com_q.lost  <= cap_lost | (com_vld & ~grant);
    end else if (grant) begin
      com_vld <= 1'b0;
    end
  end

  assign req     = com_vld;
  assign evt     = com_q;
  assign cap_ovr = cap_lost;
endmodule

// File: rtl/tsc_rr_arb.sv
// Round-robin arbiter: the search starts just past the last granted index.
module tsc_rr_arb #(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 1; i <= N; i++) begin
      logic [IDX_W-1:0] cand;
      cand = IDX_W'((int'(last_q) + i) % N);
      if (!found && req[cand]) begin
        found     = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = cand;
      end
    end
  end

  assign any = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              last_q <= IDX_W'(N - 1);
    else if (advance && any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/tsc_out_stage.sv
// Output register of the event stream; refills on the edge it empties.
module tsc_out_stage
  import tsc_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  stamp_evt_t       evt_in,
  input  logic [SRC_W-1:0] src_in,
  input  logic             ready,
  output logic             load,
  output logic             valid,
  output stamp_evt_t       evt_q,
  output logic [SRC_W-1:0] src_q
);
  logic valid_q;

  assign load  = any_req & (~valid_q | ready);
  assign valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      evt_q   <= '0;
      src_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      evt_q   <= evt_in;
      src_q   <= src_in;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture
  import tsc_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int NUM_SRC   = 2 * NUM_PORTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TS_W-1:0]           ts_count,
  input  logic [NUM_PORTS-1:0]      rx_sfd,
  input  logic [NUM_PORTS-1:0]      tx_sfd,
  input  logic [NUM_PORTS-1:0]      rx_vd_valid,
  input  logic [NUM_PORTS-1:0]      rx_vd_keep,
  input  logic [NUM_PORTS*ID_W-1:0] rx_vd_msgid,
  input  logic [NUM_PORTS-1:0]      tx_vd_valid,
  input  logic [NUM_PORTS-1:0]      tx_vd_keep,
  input  logic [NUM_PORTS*ID_W-1:0] tx_vd_msgid,
  output logic                      evt_valid,
  input  logic                      evt_ready,
  output logic                      evt_dir,
  output logic [PORT_W-1:0]         evt_port,
  output logic [ID_W-1:0]           evt_msgid,
  output logic [TS_W-1:0]           evt_ts,
  output logic                      evt_lost,
  output logic [NUM_SRC-1:0]        ovr_flag
);
  localparam int SRC_W = $clog2(NUM_SRC);

  // Source s = dir*NUM_PORTS + port; receive occupies the low half.
  logic [NUM_SRC-1:0]      sfd_all;
  logic [NUM_SRC-1:0]      vv_all;
  logic [NUM_SRC-1:0]      keep_all;
  logic [NUM_SRC*ID_W-1:0] id_all;
  logic [NUM_SRC-1:0]      req;
  logic [NUM_SRC-1:0]      gnt;
  logic [NUM_SRC-1:0]      slot_gnt;
  logic [SRC_W-1:0]        gnt_idx;
  logic                    any_req;
  logic                    load;
  stamp_evt_t              slot_evt [NUM_SRC];
  stamp_evt_t              out_evt;
  logic [SRC_W-1:0]        out_src;
  logic [SRC_W-1:0]        port_full;

  assign sfd_all  = {tx_sfd, rx_sfd};
  assign vv_all   = {tx_vd_valid, rx_vd_valid};
  assign keep_all = {tx_vd_keep, rx_vd_keep};
  assign id_all   = {tx_vd_msgid, rx_vd_msgid};
  assign slot_gnt = gnt & {NUM_SRC{load}};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    tsc_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .sfd      (sfd_all[s]),
      .ts_now   (ts_count),
      .vd_valid (vv_all[s]),
      .vd_keep  (keep_all[s]),
      .vd_msgid (id_all[s*ID_W +: ID_W]),
      .grant    (slot_gnt[s]),
      .req      (req[s]),
      .evt      (slot_evt[s]),
      .cap_ovr  (ovr_flag[s])
    );
  end

  tsc_rr_arb #(.N(NUM_SRC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .advance (load),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any_req)
  );

  tsc_out_stage #(.SRC_W(SRC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_req (any_req),
    .evt_in  (slot_evt[gnt_idx]),
    .src_in  (gnt_idx),
    .ready   (evt_ready),
    .load    (load),
    .valid   (evt_valid),
    .evt_q   (out_evt),
    .src_q   (out_src)
  );

  always_comb begin
    if (out_src >= SRC_W'(NUM_PORTS)) begin
      evt_dir   = 1'b1;
      port_full = out_src - SRC_W'(NUM_PORTS);
    end else begin
      evt_dir   = 1'b0;
      port_full = out_src;
    end
  end

  assign evt_port  = port_full[PORT_W-1:0];
  assign evt_msgid = out_evt.msgid;
  assign evt_ts    = out_evt.ts;
  assign evt_lost  = out_evt.lost;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] sfd,
  input logic [NUM_SRC-1:0] vd_valid,
  input logic [NUM_SRC-1:0] ovr,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic               evt_dir,
  input logic [PW-1:0]      evt_port,
  input logic [ID_W-1:0]    evt_msgid,
  input logic [TS_W-1:0]    evt_ts,
  input logic               evt_lost
);
  a_r11_idle_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!evt_valid && ovr == '0));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_ts) && $stable(evt_msgid)
      && $stable(evt_lost) && $stable(evt_port) && $stable(evt_dir));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    a_r5_flag_needs_sfd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr[s]) |-> $past(sfd[s]));

    a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ovr[s] && vd_valid[s] && !sfd[s] |=> !ovr[s]);

    a_r6_fresh_capture: assert property (@(posedge clk) disable iff (!rst_n)
      sfd[s] && vd_valid[s] |=> !ovr[s]);
  end
endmodule

bind ptp_stamp_capture tsc_checker #(.NUM_SRC(2 * NUM_PORTS), .PW(PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sfd       ({tx_sfd, rx_sfd}),
  .vd_valid  ({tx_vd_valid, rx_vd_valid}),
  .ovr       (ovr_flag),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_dir   (evt_dir),
  .evt_port  (evt_port),
  .evt_msgid (evt_msgid),
  .evt_ts    (evt_ts),
  .evt_lost  (evt_lost)
);

// File: tb/tb_ptp_stamp_capture.sv
module tb_ptp_stamp_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ts_count;
  logic [3:0]  rx_sfd, tx_sfd, rx_vv, tx_vv, rx_keep, tx_keep;
  logic [63:0] rx_id, tx_id;
  logic        evt_ready;
  logic        evt_valid, evt_dir, evt_lost;
  logic [1:0]  evt_port;
  logic [15:0] evt_msgid;
  logic [31:0] evt_ts;
  logic [7:0]  ovr_flag;

  always #4 clk = ~clk;

  ptp_stamp_capture dut (
    .clk(clk), .rst_n(rst_n), .ts_count(ts_count),
    .rx_sfd(rx_sfd), .tx_sfd(tx_sfd),
    .rx_vd_valid(rx_vv), .rx_vd_keep(rx_keep), .rx_vd_msgid(rx_id),
    .tx_vd_valid(tx_vv), .tx_vd_keep(tx_keep), .tx_vd_msgid(tx_id),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_dir(evt_dir),
    .evt_port(evt_port), .evt_msgid(evt_msgid), .evt_ts(evt_ts),
    .evt_lost(evt_lost), .ovr_flag(ovr_flag)
  );

  // stimulus for the next edge, indexed by source dir*4+port
  logic [7:0]  d_sfd, d_vv, d_keep;
  logic [15:0] d_id [8];
  logic        d_rdy;
  logic [31:0] tcnt;
  bit          model_on;
  // reference model built from the requirements
  bit          m_pend [8];
  logic [31:0] m_ts   [8];
  bit          m_lost [8];
  bit          e_vld  [8];
  logic [31:0] e_ts   [8];
  logic [15:0] e_id   [8];
  bit          e_lost [8];
  int          n_vec, n_bad;
  logic [31:0] t1, t2, t3;

  task automatic chkeq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int cur_src();
    return int'(evt_dir) * 4 + int'(evt_port);
  endfunction

  task automatic idle();
    d_sfd = '0; d_vv = '0; d_keep = '0;
  endtask

  // Called at a negedge: score the handshake of the coming edge, drive, advance.
  task automatic cycle();
    if (model_on && evt_valid && d_rdy) begin
      int s;
      s = cur_src();
      chkeq("R2 event expected on source", 64'(e_vld[s]), 64'd1);
      chkeq("R1 timestamp", 64'(evt_ts), 64'(e_ts[s]));
      chkeq("R2 msgid", 64'(evt_msgid), 64'(e_id[s]));
      chkeq("R5 lost bit", 64'(evt_lost), 64'(e_lost[s]));
      e_vld[s] = 1'b0;
    end
    rx_sfd = d_sfd[3:0];  tx_sfd  = d_sfd[7:4];
    rx_vv  = d_vv[3:0];   tx_vv   = d_vv[7:4];
    rx_keep = d_keep[3:0]; tx_keep = d_keep[7:4];
    for (int p = 0; p < 4; p++) begin
      rx_id[p*16 +: 16] = d_id[p];
      tx_id[p*16 +: 16] = d_id[p+4];
    end
    evt_ready = d_rdy;
    ts_count  = tcnt;
    for (int s = 0; s < 8; s++) begin
      bit hit;
      hit = d_vv[s] && m_pend[s];
      if (hit && d_keep[s]) begin
        e_vld[s] = 1'b1; e_ts[s] = m_ts[s]; e_id[s] = d_id[s]; e_lost[s] = m_lost[s];
      end
      if (d_sfd[s]) begin
        m_lost[s] = m_pend[s] && !hit; m_pend[s] = 1'b1; m_ts[s] = tcnt;
      end else if (hit) begin
        m_pend[s] = 1'b0; m_lost[s] = 1'b0;
      end
    end
    tcnt = tcnt + 32'd1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(64'd8 * 64'd200000);
    n_bad++;
    $display("FAIL R9 watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1588));
    n_vec = 0; n_bad = 0; model_on = 0;
    tcnt = 32'h0000_1000;
    idle(); d_rdy = 1'b0;
    for (int s = 0; s < 8; s++) d_id[s] = '0;
    rx_sfd = '0; tx_sfd = '0; rx_vv = '0; tx_vv = '0; rx_keep = '0; tx_keep = '0;
    rx_id = '0; tx_id = '0; evt_ready = 1'b0; ts_count = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chkeq("R11 evt_valid in reset", 64'(evt_valid), 64'd0);
    chkeq("R11 ovr_flag in reset", 64'(ovr_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: all eight commit together, drain in order 0..7 from reset
    d_rdy = 1'b0; t1 = tcnt;
    d_sfd = 8'hFF; cycle(); idle();
    d_vv = 8'hFF; d_keep = 8'hFF;
    for (int s = 0; s < 8; s++) d_id[s] = 16'(16'hA0 + s);
    cycle(); idle();
    cycle();
    chkeq("R8 first grant after reset", 64'(cur_src()), 64'd0);
    cycle();
    chkeq("R9 held while stalled valid", 64'(evt_valid), 64'd1);
    chkeq("R9 held while stalled msgid", 64'(evt_msgid), 64'hA0);
    for (int k = 0; k < 8; k++) begin
      chkeq("R8 round-robin order", 64'(cur_src()), 64'(k));
      chkeq("R2 msgid per source", 64'(evt_msgid), 64'(16'hA0 + k));
      chkeq("R1 shared capture value", 64'(evt_ts), 64'(t1));
      d_rdy = 1'b1; cycle();
    end
    chkeq("R8 all drained", 64'(evt_valid), 64'd0);

    // R1/R2: transmit port 1, latency and fields
    t1 = tcnt; d_sfd = 8'h20; cycle(); idle();
    cycle();
    d_vv = 8'h20; d_keep = 8'h20; d_id[5] = 16'hBEEF; cycle(); idle();
    chkeq("R2 not yet valid one edge after verdict", 64'(evt_valid), 64'd0);
    cycle();
    chkeq("R2 valid two edges after verdict", 64'(evt_valid), 64'd1);
    chkeq("R2 dir tx", 64'(evt_dir), 64'd1);
    chkeq("R2 port", 64'(evt_port), 64'd1);
    chkeq("R2 msgid", 64'(evt_msgid), 64'hBEEF);
    chkeq("R1 tx timestamp", 64'(evt_ts), 64'(t1));
    chkeq("R5 clean capture not lost", 64'(evt_lost), 64'd0);
    cycle();
    chkeq("R9 one event per handshake", 64'(evt_valid), 64'd0);

    // R3 discard, then R4 verdict with nothing held
    d_sfd = 8'h01; cycle(); idle();
    d_vv = 8'h01; d_keep = 8'h00; cycle(); idle();
    d_vv = 8'h01; d_keep = 8'h01; cycle(); idle();
    for (int k = 0; k < 3; k++) begin
      chkeq("R3 R4 no event", 64'(evt_valid), 64'd0);
      cycle();
    end
    chkeq("R3 no overrun left", 64'(ovr_flag), 64'd0);

    // R5: double delimiter on receive port 2
    d_sfd = 8'h04; cycle();
    t2 = tcnt; cycle(); idle();
    chkeq("R5 overrun bit set", 64'(ovr_flag), 64'h04);
    d_vv = 8'h04; d_keep = 8'h04; d_id[2] = 16'h1234; cycle(); idle();
    chkeq("R5 overrun bit cleared", 64'(ovr_flag), 64'h00);
    cycle();
    chkeq("R5 newer timestamp", 64'(evt_ts), 64'(t2));
    chkeq("R5 event lost", 64'(evt_lost), 64'd1);
    cycle();

    // R6: delimiter and verdict together on receive port 3
    t1 = tcnt; d_sfd = 8'h08; cycle();
    d_sfd = 8'h08; d_vv = 8'h08; d_keep = 8'h08; d_id[3] = 16'h0303; cycle(); idle();
    chkeq("R6 new capture clean", 64'(ovr_flag), 64'h00);
    cycle();
    chkeq("R6 older capture committed", 64'(evt_ts), 64'(t1));
    chkeq("R6 not lost", 64'(evt_lost), 64'd0);
    d_vv = 8'h08; d_keep = 8'h00; cycle(); idle();
    cycle();
    chkeq("R3 second capture discarded", 64'(evt_valid), 64'd0);

    // R7: waiting event replaced while output is stalled (tx port 2)
    d_rdy = 1'b0;
    t1 = tcnt; d_sfd = 8'h40; cycle(); idle();
    d_vv = 8'h40; d_keep = 8'h40; d_id[6] = 16'h00AA; cycle(); idle();
    cycle();
    t2 = tcnt; d_sfd = 8'h40; cycle(); idle();
    d_vv = 8'h40; d_keep = 8'h40; d_id[6] = 16'h00BB; cycle(); idle();
    t3 = tcnt; d_sfd = 8'h40; cycle(); idle();
    d_vv = 8'h40; d_keep = 8'h40; d_id[6] = 16'h00CC; cycle(); idle();
    chkeq("R9 stalled head msgid", 64'(evt_msgid), 64'h00AA);
    chkeq("R1 stalled head ts", 64'(evt_ts), 64'(t1));
    d_rdy = 1'b1; cycle();
    chkeq("R7 replacement msgid", 64'(evt_msgid), 64'h00CC);
    chkeq("R7 replacement ts", 64'(evt_ts), 64'(t3));
    chkeq("R7 replacement lost", 64'(evt_lost), 64'd1);
    cycle();
    chkeq("R7 replaced event gone", 64'(evt_valid), 64'd0);

    // R10: capture before the wrap, verdict after it
    tcnt = 32'hFFFF_FFFE;
    d_sfd = 8'h02; cycle(); idle();
    repeat (4) cycle();
    d_vv = 8'h02; d_keep = 8'h02; d_id[1] = 16'h0101; cycle(); idle();
    cycle();
    chkeq("R10 pre-wrap value kept", 64'(evt_ts), 64'hFFFF_FFFE);
    chkeq("R10 source", 64'(cur_src()), 64'd1);
    cycle();

    // random traffic scored against the model
    for (int s = 0; s < 8; s++) begin
      m_pend[s] = 0; m_lost[s] = 0; e_vld[s] = 0;
    end
    tcnt = 32'hFFFF_F800;
    model_on = 1;
    for (int k = 0; k < 4000; k++) begin
      d_rdy = ($urandom % 4) != 0;
      for (int s = 0; s < 8; s++) begin
        d_sfd[s]  = ($urandom % 12) == 0;
        d_vv[s]   = ($urandom % 6) == 0;
        d_keep[s] = (($urandom % 4) != 0) && !e_vld[s];
        d_id[s]   = 16'($urandom);
      end
      cycle();
    end
    idle(); d_rdy = 1'b1;
    repeat (30) cycle();
    for (int s = 0; s < 8; s++)
      chkeq("R2 every kept event delivered", 64'(e_vld[s]), 64'd0);
    chkeq("R3 no stray event after drain", 64'(evt_valid), 64'd0);

    summary();
    $finish;
  end
endmodule